// File: doc/BRIEF.md
# I2C Target Front End with Sticky Register Pointer

This block is the serial side of an 8-bit port expander. It oversamples the two-wire bus (SCL and SDA) with a fast system clock. It finds START, repeated START and STOP conditions and compares each address byte against a 7-bit address made of a fixed prefix and three strap inputs. For a matching address it acknowledges, then moves bytes MSB first. It drives the open-drain SDA line through a single "pull low" output.

A write transfer opens with a command byte. The two low bits of that byte are kept in a pointer that selects one of four registers: 0 input, 1 output, 2 polarity, 3 configuration. Each later byte of the same transfer becomes a one-cycle write strobe to that register. A read transfer returns the selected register repeatedly until the master stops acknowledging. The pointer does not advance. It keeps its value across repeated STARTs and read transfers until another command byte arrives.

The register contents live in a separate block. That block sees the pointer, the write strobe with its data, and a snapshot pulse that tells it when to capture the input pins for the next byte sent.

Top module: `i2c_expander_target`

## Requirements
- R1: The block acknowledges an address byte whose upper seven bits equal binary 0011 followed by `strap_i[2:0]` (0x18 to 0x1F). Bit 0 of that byte selects read (1) or write (0). For any other address it never pulls SDA low and ignores all bytes until the next START, so neither strobes nor the pointer change.
- R2: START (SDA falls while SCL is high) begins a new address phase from any state, including mid-transfer as a repeated START. STOP (SDA rises while SCL is high) returns the block to idle with SDA released.
- R3: `sda_low_o` changes only while SCL is low. It never changes during an SCL high phase.
- R4: Bits are received MSB first. Every byte of a matched write transfer is acknowledged by holding SDA low for the whole ninth clock.
- R5: The first byte after a write address is the command byte. Its two low bits load `reg_sel_o` and its upper six bits are ignored. `reg_sel_o` changes only on a command byte. It stays unchanged across repeated STARTs, read transfers and transfers to other addresses.
- R6: Each data byte after the command byte produces exactly one `wr_stb_o` pulse of one clock cycle, during that byte's ACK clock, with the byte on `wr_data_o`. All data bytes of one transfer go to the same `reg_sel_o`.
- R7: In a read transfer the block sends `rd_data_i` MSB first. It sends another byte after each master ACK (SDA low in the ninth clock). After a master NACK it keeps SDA released until the next START or STOP.
- R8: `rd_snap_o` pulses on the rising SCL edge of the ACK clock that precedes each byte sent: the address ACK of a read, and each master ACK. The byte then sent is the value the register side captured at that pulse.
- R9: While `rst_n` is low, and when it is released, the block is idle. `sda_low_o` is 0, `reg_sel_o` is 0 and `wr_stb_o` is 0. A reset during a transfer abandons that transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| strap_i | input | 3 | Low three address bits from board straps |
| sda_low_o | output | 1 | 1 = pull SDA low, 0 = release |
| reg_sel_o | output | 2 | Register pointer (0 input, 1 output, 2 polarity, 3 configuration) |
| wr_stb_o | output | 1 | One-cycle write strobe to the selected register |
| wr_data_o | output | 8 | Byte to write, valid with `wr_stb_o` |
| rd_data_i | input | 8 | Contents of the selected register |
| rd_snap_o | output | 1 | Capture pulse for the input-port snapshot |

## Verification
The hardest case to reach from the ports is the snapshot timing of a multi-byte input read. The pins must change inside the high phase of a master ACK clock, after the capture edge but before the next byte is loaded. The bench master changes the modelled pin value a quarter bit after raising SCL in that ACK clock. It then checks that the next byte carries the value from before the change. Pointer persistence is reached by mixing repeated STARTs, command-less reads and foreign-address transfers with randomly sized write/read pairs.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;
  localparam int BYTE_W = 8;
  localparam int ADDR_W = BYTE_W - 1;
  localparam int CNT_W  = $clog2(BYTE_W + 1);

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ACK_ADDR,
    ST_RX,
    ST_ACK_RX,
    ST_TX,
    ST_ACK_TX,
    ST_SKIP
  } tgt_state_e;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  // bit 1 = SCL, bit 0 = SDA
  logic [1:0] stg [STAGES];
  logic [1:0] prev_q;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      logic [1:0] stg_d;
      if (g == 0) begin : g_first
        assign stg_d = {scl_i, sda_i};
      end else begin : g_rest
        assign stg_d = stg[g-1];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[g] <= 2'b11;
        else        stg[g] <= stg_d;
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 2'b11;
    else        prev_q <= stg[STAGES-1];
  end

  assign scl_s     = stg[STAGES-1][1];
  assign sda_s     = stg[STAGES-1][0];
  assign scl_rise  = scl_s & ~prev_q[1];
  assign scl_fall  = ~scl_s & prev_q[1];
  assign start_det = scl_s & prev_q[1] & prev_q[0] & ~sda_s;
  assign stop_det  = scl_s & prev_q[1] & ~prev_q[0] & sda_s;
endmodule

// File: rtl/i2c_cmd_pointer.sv
module i2c_cmd_pointer #(
  parameter int PTR_W = 2,
  parameter logic [PTR_W-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [PTR_W-1:0] load_val,
  output logic [PTR_W-1:0] ptr
);
  logic [PTR_W-1:0] ptr_d, ptr_q;

  always_comb begin
    ptr_d = ptr_q;
    if (load) ptr_d = load_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr_q <= RST_VAL;
    else        ptr_q <= ptr_d;
  end

  assign ptr = ptr_q;
endmodule

// File: rtl/i2c_target_ctrl.sv
module i2c_target_ctrl
  import i2c_tgt_pkg::*;
#(
  parameter int STRAP_W = 3,
  parameter int PTR_W   = 2,
  parameter logic [ADDR_W-1:0] ADDR_BASE = 7'h18
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               scl_s,
  input  logic               sda_s,
  input  logic               scl_rise,
  input  logic               scl_fall,
  input  logic               start_det,
  input  logic               stop_det,
  input  logic [STRAP_W-1:0] strap,
  input  logic [BYTE_W-1:0]  rd_data,
  output logic               sda_low,
  output logic               wr_stb,
  output logic [BYTE_W-1:0]  wr_data,
  output logic               ptr_load,
  output logic [PTR_W-1:0]   ptr_val,
  output logic               rd_snap,
  output logic               in_ack_rx
);
  localparam int PREFIX_W = ADDR_W - STRAP_W;
  localparam logic [PREFIX_W-1:0] PREFIX = ADDR_BASE[ADDR_W-1 -: PREFIX_W];
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(BYTE_W);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(BYTE_W - 1);

  tgt_state_e        state_d, state_q;
  logic [CNT_W-1:0]  cnt_d, cnt_q;
  logic [BYTE_W-1:0] sh_d, sh_q;
  logic              rw_d, rw_q;
  logic              first_d, first_q;
  logic              mack_d, mack_q;
  logic              addr_hit;

  assign addr_hit = (sh_q[BYTE_W-1:1] == {PREFIX, strap});

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    sh_d    = sh_q;
    rw_d    = rw_q;
    first_d = first_q;
    mack_d  = mack_q;
    if (start_det) begin
      state_d = ST_ADDR;
      cnt_d   = '0;
    end else if (stop_det) begin
      state_d = ST_IDLE;
    end else begin
      case (state_q)
        ST_ADDR, ST_RX: begin
          if (scl_rise && cnt_q != CNT_FULL) begin
            sh_d  = {sh_q[BYTE_W-2:0], sda_s};
            cnt_d = cnt_q + CNT_W'(1);
          end
          if (scl_fall && cnt_q == CNT_FULL) begin
            if (state_q == ST_RX) begin
              state_d = ST_ACK_RX;
            end else if (addr_hit) begin
              state_d = ST_ACK_ADDR;
              rw_d    = sh_q[0];
            end else begin
              state_d = ST_SKIP;
            end
          end
        end
        ST_ACK_ADDR: begin
          if (scl_fall) begin
            cnt_d = '0;
            if (rw_q) begin
              state_d = ST_TX;
              sh_d    = rd_data;
            end else begin
              state_d = ST_RX;
              first_d = 1'b1;
            end
          end
        end
        ST_ACK_RX: begin
          if (scl_fall) begin
            state_d = ST_RX;
            cnt_d   = '0;
            first_d = 1'b0;
          end
        end
        ST_TX: begin
          if (scl_fall) begin
            if (cnt_q == CNT_LAST) begin
              state_d = ST_ACK_TX;
            end else begin
              sh_d  = {sh_q[BYTE_W-2:0], 1'b1};
              cnt_d = cnt_q + CNT_W'(1);
            end
          end
        end
        ST_ACK_TX: begin
          if (scl_rise) mack_d = ~sda_s;
          if (scl_fall) begin
            if (mack_q) begin
              state_d = ST_TX;
              sh_d    = rd_data;
              cnt_d   = '0;
            end else begin
              state_d = ST_SKIP;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      sh_q    <= '0;
      rw_q    <= 1'b0;
      first_q <= 1'b0;
      mack_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      sh_q    <= sh_d;
      rw_q    <= rw_d;
      first_q <= first_d;
      mack_q  <= mack_d;
    end
  end

  assign sda_low   = (state_q == ST_ACK_ADDR) || (state_q == ST_ACK_RX) ||
                     ((state_q == ST_TX) && !sh_q[BYTE_W-1]);
  assign in_ack_rx = (state_q == ST_ACK_RX);
  assign wr_stb    = in_ack_rx && scl_rise && !first_q;
  assign ptr_load  = in_ack_rx && scl_rise && first_q;
  assign wr_data   = sh_q;
  assign ptr_val   = sh_q[PTR_W-1:0];
  assign rd_snap   = scl_rise && (((state_q == ST_ACK_ADDR) && rw_q) ||
                                  ((state_q == ST_ACK_TX) && !sda_s));

  // R3: the data drive holds still across an SCL high phase
  assert_sda_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_s && !scl_rise) |-> $stable(sda_low));

  // R6: a write strobe is a single-cycle pulse
  assert_stb_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |=> !wr_stb);
endmodule

// File: rtl/i2c_expander_target.sv
module i2c_expander_target
  import i2c_tgt_pkg::*;
#(
  parameter int STRAP_W     = 3,
  parameter int PTR_W       = 2,
  parameter int SYNC_STAGES = 2,
  parameter logic [ADDR_W-1:0] ADDR_BASE = 7'h18
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               scl_i,
  input  logic               sda_i,
  input  logic [STRAP_W-1:0] strap_i,
  output logic               sda_low_o,
  output logic [PTR_W-1:0]   reg_sel_o,
  output logic               wr_stb_o,
  output logic [BYTE_W-1:0]  wr_data_o,
  input  logic [BYTE_W-1:0]  rd_data_i,
  output logic               rd_snap_o
);
  logic [1:0] rst_pipe;
  logic       rst_int;
  logic       scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic       ptr_load, in_ack_rx;
  logic [PTR_W-1:0] ptr_val;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_int = rst_pipe[1];

  i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_int), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  i2c_target_ctrl #(.STRAP_W(STRAP_W), .PTR_W(PTR_W), .ADDR_BASE(ADDR_BASE)) u_ctrl (
    .clk(clk), .rst_n(rst_int), .scl_s(scl_s), .sda_s(sda_s),
    .scl_rise(scl_rise), .scl_fall(scl_fall), .start_det(start_det),
    .stop_det(stop_det), .strap(strap_i), .rd_data(rd_data_i),
    .sda_low(sda_low_o), .wr_stb(wr_stb_o), .wr_data(wr_data_o),
    .ptr_load(ptr_load), .ptr_val(ptr_val), .rd_snap(rd_snap_o),
    .in_ack_rx(in_ack_rx)
  );

  i2c_cmd_pointer #(.PTR_W(PTR_W)) u_ptr (
    .clk(clk), .rst_n(rst_int), .load(ptr_load), .load_val(ptr_val),
    .ptr(reg_sel_o)
  );

  // R2: a STOP leaves SDA released
  assert_stop_release_R2: assert property (@(posedge clk) disable iff (!rst_int)
    stop_det |=> !sda_low_o);

  // R5: the pointer moves only out of a received-byte ACK clock
  assert_ptr_on_ack_R5: assert property (@(posedge clk) disable iff (!rst_int)
    (reg_sel_o != $past(reg_sel_o)) |-> $past(in_ack_rx));
endmodule

// File: tb/i2c_expander_target_test.sv
module i2c_expander_target_test;
  localparam int Q = 5;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       scl_m = 1'b1, sda_m = 1'b1;
  logic [2:0] strap = 3'b101;
  logic       sda_low;
  logic [1:0] reg_sel;
  logic       wr_stb, rd_snap;
  logic [7:0] wr_data, rd_data;
  logic       sda_line;

  logic [7:0] stub_regs [4];
  logic [7:0] snap;
  logic [7:0] port_in = 8'h00;
  logic [7:0] exp_regs [4];
  logic [7:0] last_wr;

  int checks = 0, fails = 0, stb_cnt = 0, exp_stb = 0, viol = 0;
  bit done = 0;
  logic prev_scl = 1'b1, prev_low = 1'b0;

  always #5 clk = ~clk;

  assign sda_line = sda_m & ~sda_low;
  assign rd_data  = (reg_sel == 2'd0) ? snap : stub_regs[reg_sel];

  i2c_expander_target uut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .strap_i(strap), .sda_low_o(sda_low), .reg_sel_o(reg_sel),
    .wr_stb_o(wr_stb), .wr_data_o(wr_data), .rd_data_i(rd_data),
    .rd_snap_o(rd_snap)
  );

  // register-side stand-in reached through the block's ports
  always @(posedge clk) begin
    if (!rst_n) begin
      stub_regs[0] <= 8'h00; stub_regs[1] <= 8'h00;
      stub_regs[2] <= 8'hF0; stub_regs[3] <= 8'hFF;
      snap <= 8'h00;
    end else begin
      if (wr_stb && reg_sel != 2'd0) stub_regs[reg_sel] <= wr_data;
      if (rd_snap) snap <= port_in;
    end
  end

  always @(posedge clk) begin
    if (rst_n && wr_stb) begin stb_cnt++; last_wr = wr_data; end
    if (rst_n && scl_m && prev_scl && (sda_low !== prev_low)) viol++;
    prev_scl = scl_m;
    prev_low = sda_low;
  end

  function automatic logic [7:0] addr_byte(input logic [2:0] s, input logic rd);
    return {4'b0011, s, rd};
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic qwait(); repeat (Q) @(negedge clk); endtask

  task automatic bus_start();
    sda_m = 1'b1; qwait(); scl_m = 1'b1; qwait();
    sda_m = 1'b0; qwait(); scl_m = 1'b0; qwait();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; qwait(); scl_m = 1'b1; qwait(); sda_m = 1'b1; qwait();
  endtask

  task automatic write_bit(input logic b);
    sda_m = b; qwait(); scl_m = 1'b1; qwait(); qwait(); scl_m = 1'b0; qwait();
  endtask

  task automatic read_bit(output logic v);
    sda_m = 1'b1; qwait(); scl_m = 1'b1; qwait(); v = sda_line; qwait();
    scl_m = 1'b0; qwait();
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack);
    logic v;
    for (int i = 7; i >= 0; i--) write_bit(b[i]);
    read_bit(v);
    ack = (v == 1'b0);
  endtask

  task automatic recv_byte(input bit give_ack, input logic [7:0] pre, input logic [7:0] post,
                           output logic [7:0] b);
    logic v;
    for (int i = 7; i >= 0; i--) begin read_bit(v); b[i] = v; end
    port_in = pre;
    sda_m = give_ack ? 1'b0 : 1'b1; qwait(); scl_m = 1'b1; qwait();
    port_in = post; qwait(); scl_m = 1'b0; qwait();
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    bit ack;
    logic v;
    logic [7:0] b;
    void'($urandom(32'h5EED));
    exp_regs[0] = 8'h00; exp_regs[1] = 8'h00; exp_regs[2] = 8'hF0; exp_regs[3] = 8'hFF;

    repeat (5) @(negedge clk);
    // R9: reset state
    check(sda_low == 1'b0, "R9 sda released in reset", sda_low, 0);
    check(reg_sel == 2'd0, "R9 pointer in reset", reg_sel, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check(wr_stb == 1'b0 && sda_low == 1'b0, "R9 idle after reset", {wr_stb, sda_low}, 0);

    // R1 R4 R5 R6: write two bytes to the output register
    bus_start();
    send_byte(addr_byte(strap, 1'b0), ack); check(ack, "R1 address ack", ack, 1);
    send_byte(8'h01, ack); check(ack, "R4 command ack", ack, 1);
    send_byte(8'hA5, ack); check(ack, "R4 data ack", ack, 1);
    send_byte(8'h3C, ack); check(ack, "R4 data ack", ack, 1);
    bus_stop();
    exp_stb += 2; exp_regs[1] = 8'h3C;
    check(reg_sel == 2'd1, "R5 pointer from command", reg_sel, 1);
    check(stb_cnt == exp_stb, "R6 one strobe per byte", stb_cnt, exp_stb);
    check(last_wr == 8'h3C, "R6 strobe data", last_wr, 8'h3C);
    check(sda_low == 1'b0, "R2 released after stop", sda_low, 0);

    // R5: upper command bits ignored; R7: repeated start read, NACK release
    bus_start();
    send_byte(addr_byte(strap, 1'b0), ack);
    send_byte(8'hFE, ack);
    send_byte(8'h5A, ack); exp_stb++; exp_regs[2] = 8'h5A;
    bus_start();
    send_byte(addr_byte(strap, 1'b1), ack); check(ack, "R2 repeated start address ack", ack, 1);
    recv_byte(1'b1, port_in, port_in, b); check(b == 8'h5A, "R7 read byte 1", b, 8'h5A);
    recv_byte(1'b0, port_in, port_in, b); check(b == 8'h5A, "R7 read byte 2 same register", b, 8'h5A);
    read_bit(v); check(v == 1'b1, "R7 released after NACK", v, 1);
    bus_stop();
    check(reg_sel == 2'd2, "R5 upper bits ignored", reg_sel, 2);

    // R5: read with no command byte keeps the pointer
    bus_start();
    send_byte(addr_byte(strap, 1'b1), ack);
    recv_byte(1'b0, port_in, port_in, b); check(b == 8'h5A, "R5 sticky pointer read", b, 8'h5A);
    bus_stop();

    // R1: foreign address ignored
    bus_start();
    send_byte(addr_byte(strap ^ 3'b001, 1'b0), ack); check(!ack, "R1 foreign address nack", ack, 0);
    send_byte(8'h03, ack); check(!ack, "R1 foreign byte nack", ack, 0);
    send_byte(8'hFF, ack);
    bus_stop();
    check(reg_sel == 2'd2, "R1 pointer untouched", reg_sel, 2);
    check(stb_cnt == exp_stb, "R1 no strobes", stb_cnt, exp_stb);

    // R8: input snapshot at the ACK clock rising edge
    bus_start();
    send_byte(addr_byte(strap, 1'b0), ack);
    send_byte(8'h00, ack);
    bus_stop();
    port_in = 8'h11;
    bus_start();
    send_byte(addr_byte(strap, 1'b1), ack);
    recv_byte(1'b1, 8'h22, 8'h33, b); check(b == 8'h11, "R8 first snapshot", b, 8'h11);
    recv_byte(1'b0, 8'h33, 8'h33, b); check(b == 8'h22, "R8 value at ack rise", b, 8'h22);
    bus_stop();

    // random write/read-back pairs
    for (int it = 0; it < 24; it++) begin
      logic [1:0] p;
      int n, m;
      logic [7:0] d;
      strap = 3'($urandom);
      p = 2'(1 + $urandom % 3);
      n = 1 + $urandom % 4;
      m = 1 + $urandom % 3;
      bus_start();
      send_byte(addr_byte(strap, 1'b0), ack); check(ack, "R1 random address ack", ack, 1);
      send_byte({6'($urandom), p}, ack);
      for (int k = 0; k < n; k++) begin
        d = 8'($urandom);
        send_byte(d, ack); check(ack, "R4 random data ack", ack, 1);
        exp_regs[p] = d;
      end
      exp_stb += n;
      bus_start();
      send_byte(addr_byte(strap, 1'b1), ack);
      for (int k = 0; k < m; k++) begin
        recv_byte(k != m - 1, port_in, port_in, b);
        check(b == exp_regs[p], "R7 random read", b, exp_regs[p]);
      end
      bus_stop();
      check(reg_sel == p, "R5 random pointer", reg_sel, p);
      check(stb_cnt == exp_stb, "R6 random strobe count", stb_cnt, exp_stb);
    end

    // R9: reset mid-transfer
    bus_start();
    send_byte(addr_byte(strap, 1'b0), ack);
    send_byte(8'h03, ack);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    check(reg_sel == 2'd0 && sda_low == 1'b0, "R9 reset mid-transfer", {reg_sel, sda_low}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    bus_stop();

    check(viol == 0, "R3 no drive change while SCL high", viol, 0);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule